// File: doc/BRIEF.md
# Saturating Float-to-Nibble Conversion Unit

This unit is one execution slot of a RISC-V core whose floating-point values sit in the integer register file. It watches the instruction stream for one custom OP-FP sub-instruction. When it sees that instruction, it reads the source operand as an IEEE-754 single-precision number and converts it to an unsigned integer in the range 0 to 15. The typical use is turning a shaded intensity into a 4-bit colour channel.

Each claimed instruction produces one registered result one clock later. The result comes with the destination register index taken from the instruction word, and it is zero-extended to 32 bits for write-back. The unit ignores words it does not recognise. The rest of the FPU and the register file are outside this block. The upstream stage delivers the rs1 operand alongside the instruction.

Top module: `f2u4sat_unit`

## Requirements
- R1: A word is claimed when `in_valid_i` is high, `instr_i[6:0]` equals 7'b1010011 and `instr_i[31:25]` equals 7'b1100001. For each claimed word, `out_valid_o` is high on the next cycle.
- R2: When `out_valid_o` is high, `rd_idx_o` equals bits 11:7 of the claimed word. The encoding with rd=10 and rs1=11 and all other fields zero is 32'hC2058553.
- R3: A word with a different opcode or funct7, or any word presented with `in_valid_i` low, gives `out_valid_o` low on the next cycle. On such a cycle `rd_idx_o` and `result_o` are zero.
- R4: A positive finite operand below 15.0, including subnormals and +0, yields its value truncated toward zero.
- R5: A positive operand of 15.0 or more, including +infinity, yields 15.
- R6: An operand with the sign bit set that is not a NaN yields 0. This covers -0 and -infinity.
- R7: A NaN of either sign (exponent all ones, non-zero fraction) yields 0.
- R8: Bits 31:4 of `result_o` are always zero.
- R9: While reset is held, and on the first cycle after it is released, `out_valid_o`, `rd_idx_o` and `result_o` are zero.
- R10: Claimed words issued on consecutive cycles each produce exactly one result, in issue order, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Instruction word and operand are valid |
| instr_i | input | 32 | Instruction word |
| rs1_data_i | input | 32 | Source operand, IEEE-754 single-precision bits |
| out_valid_o | output | 1 | Result valid |
| rd_idx_o | output | 5 | Destination register index |
| result_o | output | 32 | Zero-extended 4-bit result |

## Verification
Some operands fall under two clamping rules at once. A negative operand of large magnitude, such as -infinity or -1e9, matches both the upper clamp and the negative clamp, and it must resolve to 0. An infinity exponent with a non-zero fraction is a NaN, not an infinity, so it must not saturate to 15. The bench sends these operands directly, in both signs, and between ordinary in-range values. It also mixes in random encodings. A reference model built from real arithmetic gives the expected value, and the scoreboard compares it against every result in issue order.

// File: rtl/f2u4_pkg.sv
package f2u4_pkg;
    localparam int XLEN      = 32;
    localparam int REG_IDX_W = 5;
    localparam int OPC_W     = 7;
    localparam int FN7_W     = 7;
    localparam int RES_W     = 4;
    localparam int EXP_W     = 8;
    localparam int MAN_W     = 23;

    localparam logic [OPC_W-1:0] OPC_OP_FP   = 7'b1010011;
    localparam logic [FN7_W-1:0] FN7_CVT_U4S = 7'b1100001;

    typedef struct packed {
        logic                 vld;
        logic [REG_IDX_W-1:0] rd;
        logic [RES_W-1:0]     res;
    } f2u4_state_t;
endpackage

// File: rtl/f2u4_decode.sv
module f2u4_decode
    import f2u4_pkg::*;
(
    input  logic                 valid_i,
    input  logic [XLEN-1:0]      word_i,
    output logic                 claim_o,
    output logic [REG_IDX_W-1:0] rd_o
);
    localparam int RD_LSB  = 7;
    localparam int FN7_LSB = XLEN - FN7_W;

    logic opc_hit;
    logic fn7_hit;

    always_comb begin
        opc_hit = (word_i[OPC_W-1:0] == OPC_OP_FP);
        fn7_hit = (word_i[XLEN-1:FN7_LSB] == FN7_CVT_U4S);
        claim_o = valid_i && opc_hit && fn7_hit;
        rd_o    = word_i[RD_LSB +: REG_IDX_W];
    end
endmodule

// File: rtl/f2u4_convert.sv
module f2u4_convert #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int RES_W = 4
) (
    input  logic [EXP_W+MAN_W:0] flt_i,
    output logic [RES_W-1:0]     val_o
);
    localparam int          BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int          TOP_EXP = BIAS + RES_W - 1;
    localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'(TOP_EXP);
    localparam logic [EXP_W-1:0] EXP_MAX = '1;

    logic               sgn;
    logic [EXP_W-1:0]   expo;
    logic [MAN_W-1:0]   frac;
    logic [EXP_W-1:0]   rsh;
    logic [RES_W-1:0]   lead;
    logic               is_nan;

    always_comb begin
        sgn    = flt_i[EXP_W+MAN_W];
        expo   = flt_i[EXP_W+MAN_W-1:MAN_W];
        frac   = flt_i[MAN_W-1:0];
        is_nan = (expo == EXP_MAX) && (frac != '0);
        lead   = {1'b1, frac[MAN_W-1 -: RES_W-1]};
        rsh    = EXP_TOP - expo;
        if (is_nan || sgn) begin
            val_o = '0;
        end else if (expo > EXP_TOP) begin
            val_o = '1;
        end else if (expo < EXP_ONE) begin
            val_o = '0;
        end else begin
            val_o = lead >> rsh;
        end
    end
endmodule

// File: rtl/f2u4sat_unit.sv
module f2u4sat_unit
    import f2u4_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        in_valid_i,
    input  logic [31:0] instr_i,
    input  logic [31:0] rs1_data_i,
    output logic        out_valid_o,
    output logic [4:0]  rd_idx_o,
    output logic [31:0] result_o
);
    logic                 claim;
    logic [REG_IDX_W-1:0] rd_dec;
    logic [RES_W-1:0]     nib;
    f2u4_state_t          st_d;
    f2u4_state_t          st_q;

    f2u4_decode u_dec (
        .valid_i (in_valid_i),
        .word_i  (instr_i),
        .claim_o (claim),
        .rd_o    (rd_dec)
    );

    f2u4_convert #(
        .EXP_W (EXP_W),
        .MAN_W (MAN_W),
        .RES_W (RES_W)
    ) u_cvt (
        .flt_i (rs1_data_i),
        .val_o (nib)
    );

    always_comb begin
        st_d     = '0;
        st_d.vld = claim;
        if (claim) begin
            st_d.rd  = rd_dec;
            st_d.res = nib;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.vld;
    assign rd_idx_o    = st_q.rd;
    assign result_o    = {{(XLEN-RES_W){1'b0}}, st_q.res};
endmodule

// File: rtl/f2u4sat_chk.sv
module f2u4sat_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        in_valid_i,
    input logic [31:0] instr_i,
    input logic [31:0] rs1_data_i,
    input logic        out_valid_o,
    input logic [4:0]  rd_idx_o,
    input logic [31:0] result_o
);
    logic hit;
    assign hit = in_valid_i && (instr_i[6:0] == 7'b1010011)
                 && (instr_i[31:25] == 7'b1100001);

    // R1
    claim_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |=> out_valid_o);

    // R3
    no_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit |=> !out_valid_o);

    // R2
    rd_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |=> (rd_idx_o == $past(instr_i[11:7])));

    // R6
    negative_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit && rs1_data_i[31]) |=> (result_o == 32'd0));

    // R5
    pos_inf_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit && rs1_data_i == 32'h7F80_0000) |=> (result_o == 32'd15));

    // R8
    zero_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> (result_o[31:4] == 28'd0));

    // R3
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_valid_o |-> (result_o == 32'd0 && rd_idx_o == 5'd0));
endmodule

bind f2u4sat_unit f2u4sat_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .instr_i     (instr_i),
    .rs1_data_i  (rs1_data_i),
    .out_valid_o (out_valid_o),
    .rd_idx_o    (rd_idx_o),
    .result_o    (result_o)
);

// File: tb/sim_f2u4sat_unit.sv
module sim_f2u4sat_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs1 = '0;
    logic        out_valid;
    logic [4:0]  rd_idx;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [4:0]  q_rd[$];
    logic [31:0] q_res[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    f2u4sat_unit u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .in_valid_i  (in_valid),
        .instr_i     (instr),
        .rs1_data_i  (rs1),
        .out_valid_o (out_valid),
        .rd_idx_o    (rd_idx),
        .result_o    (result)
    );

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] rs,
                                       input logic [4:0] rd, input logic [6:0] opc);
        return {f7, 5'd0, rs, 3'd0, rd, opc};
    endfunction

    function automatic logic [31:0] model(input logic [31:0] b);
        int  e;
        real v;
        e = int'(b[30:23]);
        if (e == 255) return (b[22:0] != 0 || b[31]) ? 32'd0 : 32'd15;
        if (b[31]) return 32'd0;
        v = (((e == 0) ? 0.0 : 1.0) + real'(b[22:0]) / 8388608.0)
            * (2.0 ** real'(((e == 0) ? 1 : e) - 127));
        if (v >= 15.0) return 32'd15;
        return 32'($rtoi(v));
    endfunction

    task automatic fail(input string tag, input logic [31:0] act, input logic [31:0] exp);
        errors++;
        $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    endtask

    task automatic issue(input logic v, input logic [31:0] ins, input logic [31:0] d,
                         input string tag);
        @(negedge clk);
        in_valid = v;
        instr    = ins;
        rs1      = d;
        if (v && ins[6:0] == 7'b1010011 && ins[31:25] == 7'b1100001) begin
            q_rd.push_back(ins[11:7]);
            q_res.push_back(model(d));
            q_tag.push_back(tag);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always begin
        @(posedge clk);
        #1;
        if (rst_n && !done) begin
            checks++;
            if (out_valid) begin
                if (q_res.size() == 0) begin
                    fail("R3 unexpected valid", 32'd1, 32'd0);
                end else begin
                    logic [4:0]  erd;
                    logic [31:0] eres;
                    string       t;
                    erd  = q_rd.pop_front();
                    eres = q_res.pop_front();
                    t    = q_tag.pop_front();
                    if (rd_idx !== erd) fail({t, " R2 rd"}, 32'(rd_idx), 32'(erd));
                    else if (result !== eres) fail(t, result, eres);
                end
            end else begin
                if (q_res.size() != 0 && !in_valid) begin
                    // pending item missing its cycle: R10
                end
                if (result !== 32'd0 || rd_idx !== 5'd0)
                    fail("R3 idle outputs", result, 32'd0);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] cvt;
        cvt = mk(7'b1100001, 5'd11, 5'd10, 7'b1010011);
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (out_valid !== 1'b0 || result !== 32'd0 || rd_idx !== 5'd0)
            fail("R9 in reset", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        checks++;
        if (out_valid !== 1'b0 || result !== 32'd0)
            fail("R9 after reset", {31'd0, out_valid}, 32'd0);
        checks++;
        if (cvt !== 32'hC2058553) fail("R2 encoding", cvt, 32'hC2058553);

        // R4 in-range truncation
        issue(1, cvt, 32'h0000_0000, "R4 +0");
        issue(1, mk(7'b1100001, 5'd1, 5'd3, 7'b1010011), 32'h3F80_0000, "R4 1.0");
        issue(1, mk(7'b1100001, 5'd2, 5'd31, 7'b1010011), 32'h3F40_0000, "R4 0.75");
        issue(1, mk(7'b1100001, 5'd4, 5'd7, 7'b1010011), 32'h40FC_CCCD, "R4 7.9");
        issue(1, mk(7'b1100001, 5'd5, 5'd1, 7'b1010011), 32'h416F_D70A, "R4 14.99");
        issue(1, cvt, 32'h0000_0001, "R4 subnormal");
        // R5 saturation
        issue(1, cvt, 32'h4170_0000, "R5 15.0");
        issue(1, cvt, 32'h4178_0000, "R5 15.5");
        issue(1, cvt, 32'h4E6E_6B28, "R5 1e9");
        issue(1, cvt, 32'h7F80_0000, "R5 +inf");
        idle();
        // R6 negatives, including clamp overlap
        issue(1, cvt, 32'h8000_0000, "R6 -0");
        issue(1, cvt, 32'hC040_0000, "R6 -3.0");
        issue(1, cvt, 32'hFF80_0000, "R6 -inf");
        issue(1, cvt, 32'hCE6E_6B28, "R6 -1e9");
        // R7 NaNs
        issue(1, cvt, 32'h7FC0_0000, "R7 +qNaN");
        issue(1, cvt, 32'h7F80_0001, "R7 +sNaN");
        issue(1, cvt, 32'hFFC0_0000, "R7 -NaN");
        issue(1, cvt, 32'h4140_0000, "R4 12.0 after NaN");
        // R3 unclaimed words interleaved
        issue(1, mk(7'b1100000, 5'd11, 5'd10, 7'b1010011), 32'h4140_0000, "R3 funct7");
        issue(1, mk(7'b1100001, 5'd11, 5'd10, 7'b0110011), 32'h4140_0000, "R3 opcode");
        issue(0, cvt, 32'h4140_0000, "R3 valid low");
        issue(1, cvt, 32'h4100_0000, "R10 8.0 after gap");
        // R10 random back-to-back mix
        for (int i = 0; i < 300; i++) begin
            logic [31:0] w;
            logic [31:0] d;
            w = $urandom;
            if ($urandom_range(0, 3) != 0) begin
                w[6:0]   = 7'b1010011;
                w[31:25] = 7'b1100001;
            end
            d = $urandom;
            if ($urandom_range(0, 1) == 0) d[30:23] = 8'($urandom_range(120, 133));
            issue($urandom_range(0, 7) != 0, w, d, "R10 random");
        end
        idle();
        idle();
        idle();
        checks++;
        if (q_res.size() != 0) fail("R10 missing results", 32'(q_res.size()), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule